// File: doc/BRIEF.md
# Glitch-Gated Split Adder/Subtractor

This block adds or subtracts two two's-complement operands in a datapath cut into a lower slice and an upper slice. The lower slice is always computed. The upper slice is often predictable: each upper operand byte is pure sign extension (all zeros or all ones), and at least one of them is negative. In that case the upper slice's result depends only on those two patterns and on the carry leaving the lower slice. When that holds, the operands of the upper adder are forced to zero by AND gating, so the adder does not toggle. The upper half of the result is then rebuilt by a small sign-extension unit.

The decision uses three flags: close (the upper adder is shut off), sign (both upper patterns are all ones) and carr_ctrl (the lower-slice carry). These flags are captured in single-bit registers together with the operands, so transients in the detection logic never reach the gates. The registered close flag is the state of a two-state machine. In HI_ACTIVE the upper adder produces the upper result. In HI_GATED the adder sees zeros and the sign-extension unit drives the upper result. The transition GATE leads from HI_ACTIVE to HI_GATED when the next operand pair qualifies. The transition WAKE leads back when it does not. A pair that leaves the decision unchanged keeps the current state.

The block has two register stages and accepts one operand pair per cycle. Subtraction is selected per operand pair. The default split is 8 + 8 bits of a 16-bit word; other splits, such as 8 + 7 or 8 + 9, are set by parameters.

Top module: `spst_addsub`

## Requirements
- R1: With `sub_i`=0 the result is (a+b) mod 2^WIDTH; with `sub_i`=1 it is (a−b) mod 2^WIDTH, formed as a + ~b + 1. The result appears on `result_o` at the second rising edge after the operands are sampled, and a new pair is accepted every cycle.
- R2: While reset is held, and at the first edge after it, `result_o` is 0 and `hi_skipped_o` is 0 (state HI_ACTIVE).
- R3: `hi_skipped_o`, aligned with its result, is 1 exactly when both upper bytes are all-zeros or all-ones and not both all-zeros. The upper bytes are a[15:8] and the possibly inverted b[15:8]. While skipped, the upper adder's operands and carry are zero.
- R4: Skipped, one upper byte all ones and the other all zeros, lower carry 0: upper result byte is all ones.
- R5: Skipped, mixed patterns, lower carry 1: upper result byte is all zeros.
- R6: Skipped, both upper bytes all ones, lower carry 0: upper result byte is 1111_1110.
- R7: Skipped, both upper bytes all ones, lower carry 1: upper result byte is all ones.
- R8: Swapping the operands of an addition gives the same result and the same skip decision.
- R9: Two non-negative sign-extension patterns (both upper bytes zero) are not skipped; the upper adder computes the byte.
- R10: Back-to-back pairs that alternate between skipped and computed upper slices (GATE and WAKE on consecutive cycles) each give the correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| sub_i | input | 1 | 1 selects A−B, 0 selects A+B |
| result_o | output | WIDTH | Registered sum or difference |
| hi_skipped_o | output | 1 | 1 when this result's upper slice came from the sign-extension unit |

## Verification
On every cycle, the assertions compare the registered result against an independently pipelined A±B. They also compare the skip flag against the sign-pattern rule. They check that the upper adder's inputs are held at zero whenever the state is HI_GATED, and that a skipped upper byte always has one of the few shapes compensation can produce. Only the bench's scenarios show that each of the four compensated cases actually occurs with the right byte. The same holds for operand-swap symmetry, for non-negative patterns staying on the adder, and for the GATE and WAKE transitions on consecutive cycles.

// File: rtl/spst_pkg.sv
package spst_pkg;

    typedef enum logic {
        HI_ACTIVE = 1'b0,
        HI_GATED  = 1'b1
    } hi_mode_e;

endpackage

// File: rtl/spst_lo_add.sv
module spst_lo_add #(
    parameter int LO_W = 8
) (
    input  logic [LO_W-1:0] x_i,
    input  logic [LO_W-1:0] y_i,
    input  logic            cin_i,
    output logic [LO_W-1:0] sum_o,
    output logic            cout_o
);
    localparam int EXT_W = LO_W + 1;

    logic [EXT_W-1:0] wide;

    always_comb begin
        wide   = EXT_W'(x_i) + EXT_W'(y_i) + EXT_W'(cin_i);
        sum_o  = wide[LO_W-1:0];
        cout_o = wide[LO_W];
    end
endmodule

// File: rtl/spst_detect.sv
module spst_detect #(
    parameter int HI_W = 8
) (
    input  logic [HI_W-1:0] x_hi_i,
    input  logic [HI_W-1:0] y_hi_i,
    output logic            close_o,
    output logic            sign_o
);
    logic x_ones, x_zero, y_ones, y_zero;

    always_comb begin
        x_ones  = &x_hi_i;
        x_zero  = ~|x_hi_i;
        y_ones  = &y_hi_i;
        y_zero  = ~|y_hi_i;
        // predictable: both pure extension, at least one negative
        close_o = (x_ones | x_zero) & (y_ones | y_zero) & (x_ones | y_ones);
        sign_o  = x_ones & y_ones;
    end
endmodule

// File: rtl/spst_se.sv
module spst_se #(
    parameter int HI_W = 8
) (
    input  logic            sign_i,
    input  logic            carr_i,
    output logic [HI_W-1:0] hi_o
);
    generate
        if (HI_W > 1) begin : g_multi
            always_comb begin
                if (sign_i) begin
                    hi_o = {{(HI_W-1){1'b1}}, carr_i};
                end else begin
                    hi_o = {HI_W{~carr_i}};
                end
            end
        end else begin : g_single
            always_comb hi_o = sign_i ? carr_i : ~carr_i;
        end
    endgenerate
endmodule

// File: rtl/spst_addsub.sv
module spst_addsub #(
    parameter int WIDTH = 16,
    parameter int LO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] result_o,
    output logic             hi_skipped_o
);
    import spst_pkg::*;

    localparam int HI_W = WIDTH - LO_W;

    // stage 1: operand conditioning, lower slice, detection
    logic [WIDTH-1:0] b_cond;
    logic [LO_W-1:0]  lo_sum_d;
    logic             lo_carry_d;
    logic             close_d, sign_d;
    hi_mode_e         mode_d, mode_q;

    logic [HI_W-1:0]  a_hi_q, b_hi_q;
    logic [LO_W-1:0]  lo_sum_q;
    logic             carr_ctrl_q, sign_q;

    // stage 2: gated upper adder, compensation, select
    logic [HI_W-1:0]  hi_a_g, hi_b_g, hi_add, se_hi, hi_res;
    logic             hi_c_g;

    assign b_cond = sub_i ? ~b_i : b_i;

    spst_lo_add #(.LO_W(LO_W)) u_lo (
        .x_i    (a_i[LO_W-1:0]),
        .y_i    (b_cond[LO_W-1:0]),
        .cin_i  (sub_i),
        .sum_o  (lo_sum_d),
        .cout_o (lo_carry_d)
    );

    spst_detect #(.HI_W(HI_W)) u_det (
        .x_hi_i  (a_i[WIDTH-1:LO_W]),
        .y_hi_i  (b_cond[WIDTH-1:LO_W]),
        .close_o (close_d),
        .sign_o  (sign_d)
    );

    // next-state: GATE when the new pair qualifies, WAKE when it does not
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            HI_ACTIVE: if (close_d)  mode_d = HI_GATED;
            HI_GATED:  if (!close_d) mode_d = HI_ACTIVE;
            default:   mode_d = HI_ACTIVE;
        endcase
    end

    // state register plus the registered control and operand bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= HI_ACTIVE;
            sign_q      <= 1'b0;
            carr_ctrl_q <= 1'b0;
            a_hi_q      <= '0;
            b_hi_q      <= '0;
            lo_sum_q    <= '0;
        end else begin
            mode_q      <= mode_d;
            sign_q      <= sign_d;
            carr_ctrl_q <= lo_carry_d;
            a_hi_q      <= a_i[WIDTH-1:LO_W];
            b_hi_q      <= b_cond[WIDTH-1:LO_W];
            lo_sum_q    <= lo_sum_d;
        end
    end

    spst_se #(.HI_W(HI_W)) u_se (
        .sign_i (sign_q),
        .carr_i (carr_ctrl_q),
        .hi_o   (se_hi)
    );

    // output process: AND gating of the upper adder, result selection
    always_comb begin
        hi_a_g = '0;
        hi_b_g = '0;
        hi_c_g = 1'b0;
        hi_res = se_hi;
        unique case (mode_q)
            HI_ACTIVE: begin
                hi_a_g = a_hi_q & {HI_W{1'b1}};
                hi_b_g = b_hi_q & {HI_W{1'b1}};
                hi_c_g = carr_ctrl_q;
                hi_res = hi_add;
            end
            HI_GATED: begin
                hi_res = se_hi;
            end
            default: hi_res = hi_add;
        endcase
    end

    assign hi_add = hi_a_g + hi_b_g + HI_W'(hi_c_g);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o     <= '0;
            hi_skipped_o <= 1'b0;
        end else begin
            result_o     <= {hi_res, lo_sum_q};
            hi_skipped_o <= (mode_q == HI_GATED);
        end
    end
endmodule

// File: rtl/spst_addsub_chk.sv
module spst_addsub_chk #(
    parameter int WIDTH = 16,
    parameter int LO_W  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [WIDTH-1:0]      a_i,
    input logic [WIDTH-1:0]      b_i,
    input logic                  sub_i,
    input logic [WIDTH-1:0]      result_o,
    input logic                  hi_skipped_o,
    input logic                  gated,
    input logic [WIDTH-LO_W-1:0] up_a,
    input logic [WIDTH-LO_W-1:0] up_b,
    input logic                  up_c
);
    localparam int HI_W = WIDTH - LO_W;

    logic [WIDTH-1:0] pa1, pb1, pa2, pb2;
    logic             ps1, ps2, g1;
    logic [1:0]       warm;
    logic [WIDTH-1:0] exp_res, pb2_cond;
    logic [HI_W-1:0]  xa, xb, res_hi;
    logic             exp_skip;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa1 <= '0; pb1 <= '0; ps1 <= 1'b0;
            pa2 <= '0; pb2 <= '0; ps2 <= 1'b0;
            g1  <= 1'b0;
            warm <= 2'd0;
        end else begin
            pa1 <= a_i; pb1 <= b_i; ps1 <= sub_i;
            pa2 <= pa1; pb2 <= pb1; ps2 <= ps1;
            g1  <= gated;
            if (warm != 2'd2) warm <= warm + 2'd1;
        end
    end

    always_comb begin
        exp_res  = ps2 ? (pa2 - pb2) : (pa2 + pb2);
        pb2_cond = ps2 ? ~pb2 : pb2;
        xa       = pa2[WIDTH-1:LO_W];
        xb       = pb2_cond[WIDTH-1:LO_W];
        exp_skip = ((xa == '0) || (xa == '1)) && ((xb == '0) || (xb == '1))
                   && !((xa == '0) && (xb == '0));
        res_hi   = result_o[WIDTH-1:LO_W];
    end

    assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (result_o == exp_res));

    assert_reset_R2: assert property (@(posedge clk)
        $rose(rst_n) |-> (result_o == '0 && !hi_skipped_o));

    assert_skip_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (hi_skipped_o == exp_skip));

    assert_skip_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0) |-> (hi_skipped_o == g1));

    assert_gate_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gated |-> (up_a == '0 && up_b == '0 && !up_c));

    // R4..R7: a compensated byte has one of the shapes the SE unit makes
    assert_se_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hi_skipped_o |-> (res_hi == '0 || res_hi[HI_W-1:1] == '1));
endmodule

bind spst_addsub spst_addsub_chk #(.WIDTH(WIDTH), .LO_W(LO_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .a_i          (a_i),
    .b_i          (b_i),
    .sub_i        (sub_i),
    .result_o     (result_o),
    .hi_skipped_o (hi_skipped_o),
    .gated        (mode_q == spst_pkg::HI_GATED),
    .up_a         (hi_a_g),
    .up_b         (hi_b_g),
    .up_c         (hi_c_g)
);

// File: tb/tb_spst_addsub.sv
module tb_spst_addsub;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int LW = 8;

    typedef struct {
        logic [W-1:0] res;
        logic         skip;
        int           tag;
        string        req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_r = '0, b_r = '0;
    logic         sub_r = 1'b0;
    logic [W-1:0] result;
    logic         skipped;

    item_t q[$];
    int nidx = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    spst_addsub #(.WIDTH(W), .LO_W(LW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .a_i          (a_r),
        .b_i          (b_r),
        .sub_i        (sub_r),
        .result_o     (result),
        .hi_skipped_o (skipped)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) nidx <= nidx + 1;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // driver: applies one pair and pushes its expected item
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic s, input string req);
        item_t it;
        logic [W-1:0] bc;
        logic [W-LW-1:0] ha, hb;
        @(negedge clk);
        a_r = a; b_r = b; sub_r = s;
        bc = s ? ~b : b;
        ha = a[W-1:LW];
        hb = bc[W-1:LW];
        it.res  = s ? (a - b) : (a + b);
        it.skip = ((ha == '0) || (ha == '1)) && ((hb == '0) || (hb == '1))
                  && !((ha == '0) && (hb == '0));
        it.tag  = nidx;
        it.req  = req;
        q.push_back(it);
    endtask

    // monitor: compares each result two edges after its pair was applied
    always @(negedge clk) begin
        if (q.size() > 0 && (q[0].tag + 2 == nidx)) begin
            item_t it;
            it = q.pop_front();
            check(it.req, result, it.res);
            check({it.req, " skip"}, {{(W-1){1'b0}}, skipped}, {{(W-1){1'b0}}, it.skip});
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2 result", result, '0);
        check("R2 skip", {{(W-1){1'b0}}, skipped}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 after release", result, '0);

        drive(16'hFF05, 16'h0003, 1'b0, "R4 mixed c0 -> FF08");
        drive(16'hFFF0, 16'h0020, 1'b0, "R5 mixed c1 -> 0010");
        drive(16'hFF01, 16'hFF02, 1'b0, "R6 neg+neg c0 -> FE03");
        drive(16'hFF80, 16'hFF90, 1'b0, "R7 neg+neg c1 -> FF10");
        drive(16'h0005, 16'h0007, 1'b1, "R4 sub 5-7 -> FFFE");
        drive(16'h0009, 16'h0002, 1'b1, "R5 sub 9-2 -> 0007");
        drive(16'h0012, 16'h0034, 1'b0, "R9 pos+pos -> 0046");
        drive(16'h1234, 16'h0F0F, 1'b0, "R1 wide add");
        drive(16'h1234, 16'h4321, 1'b1, "R1 wide sub");
        drive(16'h0003, 16'hFF05, 1'b0, "R8 swapped mixed c0");
        drive(16'h0020, 16'hFFF0, 1'b0, "R8 swapped mixed c1");
        drive(16'hFF90, 16'hFF80, 1'b0, "R8 swapped neg c1");
        // alternate GATE / WAKE on consecutive cycles
        for (int k = 0; k < 8; k++) begin
            drive(16'hFFFE, 16'h0001, 1'b0, "R10 gated");
            drive(16'h7000, 16'h0123, 1'b0, "R10 active");
        end
        for (int k = 0; k < 300; k++) begin
            int va, vb;
            va = int'($urandom_range(0, 600)) - 300;
            vb = int'($urandom_range(0, 600)) - 300;
            drive(W'(va), W'(vb), 1'($urandom_range(0, 1)), "R10 small random");
        end
        for (int k = 0; k < 100; k++) begin
            drive(W'($urandom), W'($urandom), 1'($urandom_range(0, 1)), "R1 random");
        end
        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule